// File: doc/BRIEF.md
# Fast Context Switch Address Remapper

This block relocates low processor addresses by process, so that an operating system can switch between small processes without flushing translation caches. It holds a 7-bit process identifier and uses it to move every address in the lowest 32 MB window into one of 128 separate 32 MB regions before the address reaches the memory management unit. Addresses outside that window pass through unchanged.

Software reaches the identifier through a register access port. The port has read and write strobes, write data and read data, together with the privilege level, the security state and a security write-lock input. The identifier is banked, with one copy for the secure state and one for the non-secure state. Illegal accesses are refused and raise an undefined-instruction pulse. Each successful write raises a pipeline-flush pulse, so the next fetch uses the new identifier. The translation path is purely combinational and picks the bank that matches the security state of the issuing address.

Top module: `fcs_remapper`

## Requirements
- R1: Synchronous active-high reset clears both identifier copies to 0, and clears `undef_exc`, `flush_req` and `acc_rdata`. After reset, `mva` equals `cpu_addr` for every address.
- R2: A privileged write with `nonsecure`=0 (and `sec_wr_lock`=0) loads `acc_wdata[31:25]` into the secure copy. The non-secure copy is left unchanged.
- R3: A privileged write with `nonsecure`=1 loads `acc_wdata[31:25]` into the non-secure copy. The secure copy is left unchanged.
- R4: A read or write with `priv`=0 changes no copy. It pulses `undef_exc` high in the cycle after the access and does not raise `flush_req`.
- R5: A privileged secure write while `sec_wr_lock`=1 is refused: `undef_exc` pulses the next cycle and the secure copy keeps its value. The lock has no effect on non-secure writes.
- R6: A successful write pulses `flush_req` for one cycle, in the cycle after the write. `flush_req` and `undef_exc` are never high together.
- R7: A privileged read returns `{id, 25'b0}` of the addressed bank on `acc_rdata` in the cycle after the read. A refused read returns 0.
- R8: If `cpu_addr[31:25]`==0, then `mva` = `{id, cpu_addr[24:0]}`, which equals the address plus id times 32 MB.
- R9: If `cpu_addr[31:25]`!=0, then `mva` equals `cpu_addr`.
- R10: Translation uses the secure copy when `cpu_nonsecure`=0 and the non-secure copy when it is 1.
- R11: Bits [24:0] of `acc_wdata` are ignored on a write and always read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Register read strobe |
| acc_wr | input | 1 | Register write strobe |
| acc_wdata | input | 32 | Register write word; identifier in [31:25] |
| priv | input | 1 | 1 = privileged access |
| nonsecure | input | 1 | Security state of the register access (1 = non-secure) |
| sec_wr_lock | input | 1 | Blocks secure writes when high |
| acc_rdata | output | 32 | Read word, valid the cycle after a read |
| undef_exc | output | 1 | Undefined-instruction pulse for a refused access |
| flush_req | output | 1 | Pipeline-flush pulse after a successful write |
| cpu_addr | input | 32 | Processor address to translate |
| cpu_nonsecure | input | 1 | Security state of the address (selects bank) |
| mva | output | 32 | Modified virtual address to the MMU |

## Verification
The assertions assume that `acc_rd` and `acc_wr` are never high in the same cycle. They also assume that reset is applied before the first access, because the pulse checks compare each output with the strobes of the previous cycle. The bench drives each access for exactly one cycle and always drops both strobes afterwards, so every pulse comes from a single request. Access inputs and the translated address change only at the falling clock edge and are held through the rising edge.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int ADDR_W = 32;
    localparam int ID_W   = 7;
    localparam int OFFS_W = ADDR_W - ID_W;
    localparam int NBANK  = 2;

    typedef enum logic {
        BANK_S  = 1'b0,
        BANK_NS = 1'b1
    } bank_e;

    typedef struct packed {
        logic  rd;
        logic  wr;
        logic  priv;
        bank_e bank;
        logic  lock;
    } acc_req_t;

    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic deny;
    } acc_dec_t;

    function automatic acc_dec_t decode_access(acc_req_t r);
        acc_dec_t d;
        logic     active;
        active  = r.rd | r.wr;
        d.deny  = active & (~r.priv | (r.wr & (r.bank == BANK_S) & r.lock));
        d.wr_ok = r.wr & ~d.deny;
        d.rd_ok = r.rd & ~r.wr & ~d.deny;
        return d;
    endfunction

endpackage

// File: rtl/fcs_access_ctrl.sv
module fcs_access_ctrl
    import fcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  acc_req_t req,
    output acc_dec_t dec,
    output logic     undef_q,
    output logic     flush_q
);

    always_comb begin
        dec = decode_access(req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            undef_q <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            undef_q <= dec.deny;
            flush_q <= dec.wr_ok;
        end
    end

endmodule

// File: rtl/fcs_id_bank.sv
module fcs_id_bank
    import fcs_pkg::*;
#(
    parameter int P_ID_W  = ID_W,
    parameter int P_NBANK = NBANK
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [$clog2(P_NBANK)-1:0]       wr_sel,
    input  logic [P_ID_W-1:0]                wr_id,
    output logic [P_NBANK-1:0][P_ID_W-1:0]   ids
);

    for (genvar b = 0; b < P_NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                ids[b] <= '0;
            end else if (wr_en && (wr_sel == b)) begin
                ids[b] <= wr_id;
            end
        end
    end

endmodule

// File: rtl/fcs_remap.sv
module fcs_remap
    import fcs_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_ID_W   = ID_W
) (
    input  logic [P_ADDR_W-1:0] addr,
    input  logic [P_ID_W-1:0]   id,
    output logic [P_ADDR_W-1:0] addr_out
);

    localparam int LOW_W = P_ADDR_W - P_ID_W;

    logic in_win;

    always_comb begin
        in_win = (addr[P_ADDR_W-1:LOW_W] == '0);
        if (in_win) begin
            addr_out = {id, addr[LOW_W-1:0]};
        end else begin
            addr_out = addr;
        end
    end

endmodule

// File: rtl/fcs_remapper.sv
module fcs_remapper
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_wdata,
    input  logic              priv,
    input  logic              nonsecure,
    input  logic              sec_wr_lock,
    output logic [ADDR_W-1:0] acc_rdata,
    output logic              undef_exc,
    output logic              flush_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_nonsecure,
    output logic [ADDR_W-1:0] mva
);

    acc_req_t                      req;
    acc_dec_t                      dec;
    logic [NBANK-1:0][ID_W-1:0]    ids;
    logic [ID_W-1:0]               xlate_id;
    logic [ID_W-1:0]               rd_id;
    logic                          unused_rsvd;

    always_comb begin
        req.rd   = acc_rd;
        req.wr   = acc_wr;
        req.priv = priv;
        req.bank = bank_e'(nonsecure);
        req.lock = sec_wr_lock;
    end

    assign unused_rsvd = ^acc_wdata[OFFS_W-1:0];

    fcs_access_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .dec     (dec),
        .undef_q (undef_exc),
        .flush_q (flush_req)
    );

    fcs_id_bank #(
        .P_ID_W  (ID_W),
        .P_NBANK (NBANK)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (dec.wr_ok),
        .wr_sel (req.bank),
        .wr_id  (acc_wdata[ADDR_W-1:OFFS_W]),
        .ids    (ids)
    );

    assign rd_id    = ids[req.bank];
    assign xlate_id = ids[cpu_nonsecure];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_rdata <= '0;
        end else if (dec.rd_ok) begin
            acc_rdata <= {rd_id, {OFFS_W{1'b0}}};
        end else begin
            acc_rdata <= '0;
        end
    end

    fcs_remap #(
        .P_ADDR_W (ADDR_W),
        .P_ID_W   (ID_W)
    ) u_remap (
        .addr     (cpu_addr),
        .id       (xlate_id),
        .addr_out (mva)
    );

endmodule

// File: rtl/fcs_remapper_chk.sv
module fcs_remapper_chk
    import fcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              priv,
    input logic              nonsecure,
    input logic              sec_wr_lock,
    input logic              undef_exc,
    input logic              flush_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [ADDR_W-1:0] mva
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!undef_exc && !flush_req));

    assert_user_undef_R4: assert property (@(posedge clk) disable iff (rst)
        ((acc_rd || acc_wr) && !priv) |=> (undef_exc && !flush_req));

    assert_lock_refuse_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && priv && !nonsecure && sec_wr_lock) |=> (undef_exc && !flush_req));

    assert_flush_cause_R6: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> $past(acc_wr && priv && (nonsecure || !sec_wr_lock)));

    assert_pulse_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(undef_exc && flush_req));

    assert_low_offset_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[ADDR_W-1:OFFS_W] == '0) |-> (mva[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]));

    assert_high_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[ADDR_W-1:OFFS_W] != '0) |-> (mva == cpu_addr));

endmodule

bind fcs_remapper fcs_remapper_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_rd      (acc_rd),
    .acc_wr      (acc_wr),
    .priv        (priv),
    .nonsecure   (nonsecure),
    .sec_wr_lock (sec_wr_lock),
    .undef_exc   (undef_exc),
    .flush_req   (flush_req),
    .cpu_addr    (cpu_addr),
    .mva         (mva)
);

// File: tb/fcs_remapper_test.sv
module fcs_remapper_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_rd, acc_wr, priv, nonsecure, sec_wr_lock, cpu_nonsecure;
    logic [31:0] acc_wdata, acc_rdata, cpu_addr, mva;
    logic        undef_exc, flush_req;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    fcs_remapper uut (
        .clk           (clk),
        .rst           (rst),
        .acc_rd        (acc_rd),
        .acc_wr        (acc_wr),
        .acc_wdata     (acc_wdata),
        .priv          (priv),
        .nonsecure     (nonsecure),
        .sec_wr_lock   (sec_wr_lock),
        .acc_rdata     (acc_rdata),
        .undef_exc     (undef_exc),
        .flush_req     (flush_req),
        .cpu_addr      (cpu_addr),
        .cpu_nonsecure (cpu_nonsecure),
        .mva           (mva)
    );

    // {cpu_nonsecure, cpu_addr, expected mva}; secure id = 5, non-secure id = 7F
    localparam logic [64:0] VEC [0:7] = '{
        {1'b0, 32'h0000_1234, 32'h0A00_1234},
        {1'b0, 32'h01FF_FFFF, 32'h0BFF_FFFF},
        {1'b1, 32'h0000_0000, 32'hFE00_0000},
        {1'b1, 32'h0100_0040, 32'hFF00_0040},
        {1'b0, 32'h0200_0000, 32'h0200_0000},
        {1'b1, 32'h8000_0010, 32'h8000_0010},
        {1'b1, 32'h0200_0001, 32'h0200_0001},
        {1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // one-cycle access; returns after the registered outputs have updated
    task automatic access(logic rd, logic wr, logic pv, logic ns, logic lk, logic [31:0] wd);
        @(negedge clk);
        acc_rd = rd; acc_wr = wr; priv = pv; nonsecure = ns; sec_wr_lock = lk; acc_wdata = wd;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
        #1;
    endtask

    task automatic xlate(logic ns, logic [31:0] a);
        @(negedge clk);
        cpu_nonsecure = ns; cpu_addr = a;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; acc_rd = 0; acc_wr = 0; priv = 0; nonsecure = 0; sec_wr_lock = 0;
        acc_wdata = '0; cpu_addr = 32'h0000_1000; cpu_nonsecure = 0;
        do_reset();

        // R1: reset state
        chk("R1 undef", {31'b0, undef_exc}, 32'h0);
        chk("R1 flush", {31'b0, flush_req}, 32'h0);
        chk("R1 rdata", acc_rdata, 32'h0);
        chk("R1 flat map", mva, 32'h0000_1000);

        // R2, R6, R11: secure write with junk in reserved bits
        access(0, 1, 1, 0, 0, 32'h0A12_3456);
        chk("R6 flush pulse", {31'b0, flush_req}, 32'h1);
        chk("R6 no undef", {31'b0, undef_exc}, 32'h0);
        @(negedge clk); #1;
        chk("R6 one cycle", {31'b0, flush_req}, 32'h0);
        access(1, 0, 1, 0, 0, 32'h0);
        chk("R2 R11 secure readback", acc_rdata, 32'h0A00_0000);
        access(1, 0, 1, 1, 0, 32'h0);
        chk("R2 nonsecure untouched", acc_rdata, 32'h0);

        // R3, R5: non-secure write succeeds even with lock high
        access(0, 1, 1, 1, 1, 32'hFE00_0000);
        chk("R5 ns write flush", {31'b0, flush_req}, 32'h1);
        access(1, 0, 1, 1, 0, 32'h0);
        chk("R3 ns readback", acc_rdata, 32'hFE00_0000);
        access(1, 0, 1, 0, 0, 32'h0);
        chk("R3 secure untouched", acc_rdata, 32'h0A00_0000);

        // R5: locked secure write refused
        access(0, 1, 1, 0, 1, 32'h1200_0000);
        chk("R5 undef", {31'b0, undef_exc}, 32'h1);
        chk("R5 no flush", {31'b0, flush_req}, 32'h0);
        access(1, 0, 1, 0, 1, 32'h0);
        chk("R5 value kept", acc_rdata, 32'h0A00_0000);

        // R4: user accesses
        access(0, 1, 0, 1, 0, 32'h0200_0000);
        chk("R4 user write undef", {31'b0, undef_exc}, 32'h1);
        chk("R4 user write no flush", {31'b0, flush_req}, 32'h0);
        access(1, 0, 0, 0, 0, 32'h0);
        chk("R4 user read undef", {31'b0, undef_exc}, 32'h1);
        chk("R7 refused read zero", acc_rdata, 32'h0);
        access(1, 0, 1, 1, 0, 32'h0);
        chk("R4 ns kept", acc_rdata, 32'hFE00_0000);

        // R8, R9, R10: translation table
        for (int i = 0; i < 8; i++) begin
            xlate(VEC[i][64], VEC[i][63:32]);
            chk("R8 R9 R10 translate", mva, VEC[i][31:0]);
        end

        // R1: reset again clears banks
        do_reset();
        xlate(1, 32'h0000_0010);
        chk("R1 ns flat after reset", mva, 32'h0000_0010);
        xlate(0, 32'h01AB_CDEF);
        chk("R1 s flat after reset", mva, 32'h01AB_CDEF);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule